// File: doc/BRIEF.md
# Speculative Cell Output Arbiter

Once per cell slot this block decides which cells may pass through each output of an asymmetric crossbar. The cells in question were launched by ingress ports without waiting for a grant. Each output drives two receivers, so it can take two cells per slot. The scheduled matching for the slot is placed first. Speculative requests only fill the receivers that the scheduled matching leaves free. When an output has more speculative requesters than free receivers, a per-output round-robin pointer picks the winners.

Each speculative request is a valid bit plus a target output index. Each input can also carry a scheduled grant, given as a valid bit plus an output index. The block is told when a slot starts by a one-cycle `slot_strobe`, and it samples all request inputs in that cycle. One clock later it presents its result for one cycle:
- an acknowledge bit per input;
- for each output, the source input index on each of its two receivers.

These receiver assignments serve as the switch commands. An input whose speculation loses gets no acknowledge, and its cell waits for a later granted transmission.

Control is a two-state machine:
- `ARB_IDLE` means no result is on the outputs.
- `ARB_ISSUE` means a result is being presented.

Its transitions are:
- IDLE→ISSUE on a strobe.
- ISSUE→ISSUE on a back-to-back strobe.
- ISSUE→IDLE when no strobe follows.
- IDLE→IDLE while no strobe arrives.

Top module: `spec_out_arb`

## Requirements
- R1: `result_valid` is high in exactly the cycle after each cycle with `slot_strobe` high. In every cycle where `result_valid` is low, `spec_ack`, `rx0_valid` and `rx1_valid` are all zero.
- R2: For each output j with a scheduled cell, `rx0_valid[j]` is 1 and the receiver-0 source field of j holds that cell's input index. The scheduled matching has at most one input per output.
- R3: An output with a scheduled cell accepts at most one speculative winner, and that winner is placed on receiver 1.
- R4: An output with no scheduled cell accepts up to two speculative winners. The first winner goes on receiver 0 and the second on receiver 1. Receiver 1 is never valid while receiver 0 is idle.
- R5: Winners at an output are the first eligible requesters found when scanning input indices upward from that output's pointer and wrapping at N_IN. The pointer resets to 0. After a slot with winners, the pointer moves to one past the last winner accepted, modulo N_IN. It is unchanged after a slot with no winners.
- R6: Every winning input gets `spec_ack` set to 1, and every losing or non-requesting input gets 0.
- R7: An input with `sched_valid` set has its speculative request ignored in that slot. It gets no acknowledge, and it neither takes a receiver nor moves a pointer.
- R8: The field layout is as follows. Input i's target output sits at bits `[i*OW +: OW]` of `sched_dst` and `spec_dst`, where OW = clog2(N_OUT). Output j's source index sits at bits `[j*IW +: IW]` of `rx0_src` and `rx1_src`, where IW = clog2(N_IN).
- R9: Request inputs are ignored in cycles without `slot_strobe`. They produce no result and leave the pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_strobe | input | 1 | Marks the cycle in which the slot's requests are sampled |
| sched_valid | input | N_IN | Input holds a scheduled grant this slot |
| sched_dst | input | N_IN*OW | Scheduled target output per input |
| spec_valid | input | N_IN | Input launched a speculative cell this slot |
| spec_dst | input | N_IN*OW | Speculative target output per input |
| result_valid | output | 1 | Result fields are valid this cycle |
| spec_ack | output | N_IN | Speculation accepted, per input |
| rx0_valid | output | N_OUT | Receiver 0 of the output is switched on |
| rx0_src | output | N_OUT*IW | Source input index for receiver 0 |
| rx1_valid | output | N_OUT | Receiver 1 of the output is switched on |
| rx1_src | output | N_OUT*IW | Source input index for receiver 1 |

## Verification
Two functions can land on one output in the same slot: placing a scheduled cell and round-robin selection among speculative requesters. The same is true for one input, which can carry both a grant and a speculative request. The bench provokes the first case by aiming a scheduled cell and three speculative requests at one output, expecting exactly one speculative winner on receiver 1. It provokes the second by giving an input both a grant and a speculative request, expecting no acknowledge and an untouched pointer at the speculative target, which a later slot reveals. A reference model in the bench tracks each output's pointer from the requirements and predicts every receiver field.

// File: rtl/spec_arb_pkg.sv
`timescale 1ns/1ps
package spec_arb_pkg;

    // Result presentation state
    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_ISSUE = 1'b1
    } arb_state_t;

    // Receiver capacity codes seen by the per-output picker
    localparam logic [1:0] CAP_ONE = 2'd1;
    localparam logic [1:0] CAP_TWO = 2'd2;

    // Index width for a population of n items (at least one bit)
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/spec_rr_pick2.sv
`timescale 1ns/1ps
module spec_rr_pick2
    import spec_arb_pkg::*;
#(
    parameter int unsigned N_IN = 8
) (
    input  logic [N_IN-1:0]               req,
    input  logic [idx_width(N_IN)-1:0]    ptr,
    input  logic [1:0]                    cap,
    output logic [N_IN-1:0]               win_vec,
    output logic                          w0_v,
    output logic [idx_width(N_IN)-1:0]    w0_idx,
    output logic                          w1_v,
    output logic [idx_width(N_IN)-1:0]    w1_idx,
    output logic                          adv,
    output logic [idx_width(N_IN)-1:0]    next_ptr
);

    localparam int unsigned IW = idx_width(N_IN);

    function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] p);
        if (int'(p) == int'(N_IN) - 1) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    // Circular scan from the pointer; the first two eligible requesters
    // win, limited by the free receiver count.
    always_comb begin
        int idx;
        win_vec = '0;
        w0_v    = 1'b0;
        w0_idx  = '0;
        w1_v    = 1'b0;
        w1_idx  = '0;
        for (int k = 0; k < int'(N_IN); k++) begin
            idx = int'(ptr) + k;
            if (idx >= int'(N_IN)) begin
                idx = idx - int'(N_IN);
            end
            if (req[idx]) begin
                if (!w0_v && cap != 2'd0) begin
                    w0_v         = 1'b1;
                    w0_idx       = IW'(idx);
                    win_vec[idx] = 1'b1;
                end else if (w0_v && !w1_v && cap == CAP_TWO) begin
                    w1_v         = 1'b1;
                    w1_idx       = IW'(idx);
                    win_vec[idx] = 1'b1;
                end
            end
        end
    end

    // Pointer moves past the last winner accepted
    always_comb begin
        adv      = w0_v;
        next_ptr = ptr;
        if (w1_v) begin
            next_ptr = step_idx(w1_idx);
        end else if (w0_v) begin
            next_ptr = step_idx(w0_idx);
        end
    end

endmodule

// File: rtl/spec_out_lane.sv
`timescale 1ns/1ps
module spec_out_lane
    import spec_arb_pkg::*;
#(
    parameter int unsigned N_IN  = 8,
    parameter int unsigned N_OUT = 8,
    parameter int unsigned LANE  = 0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               slot_strobe,
    input  logic [N_IN-1:0]                    sched_valid,
    input  logic [N_IN*idx_width(N_OUT)-1:0]   sched_dst,
    input  logic [N_IN-1:0]                    spec_valid,
    input  logic [N_IN*idx_width(N_OUT)-1:0]   spec_dst,
    output logic [N_IN-1:0]                    win_vec,
    output logic                               rx0_v,
    output logic [idx_width(N_IN)-1:0]         rx0_src,
    output logic                               rx1_v,
    output logic [idx_width(N_IN)-1:0]         rx1_src
);

    localparam int unsigned IW = idx_width(N_IN);
    localparam int unsigned OW = idx_width(N_OUT);

    logic            sched_hit;
    logic [IW-1:0]   sched_src;
    logic [N_IN-1:0] elig;
    logic [1:0]      cap;
    logic [IW-1:0]   rr_ptr_q;
    logic            w0_v, w1_v, adv;
    logic [IW-1:0]   w0_idx, w1_idx, next_ptr;

    // Scheduled cell aimed at this output and eligible speculative requests
    always_comb begin
        sched_hit = 1'b0;
        sched_src = '0;
        elig      = '0;
        for (int i = 0; i < int'(N_IN); i++) begin
            if (sched_valid[i] && sched_dst[i*OW +: OW] == OW'(LANE)) begin
                sched_hit = 1'b1;
                sched_src = IW'(i);
            end
            elig[i] = spec_valid[i] && !sched_valid[i] &&
                      (spec_dst[i*OW +: OW] == OW'(LANE));
        end
        cap = sched_hit ? CAP_ONE : CAP_TWO;
    end

    spec_rr_pick2 #(.N_IN(N_IN)) u_pick (
        .req      (elig),
        .ptr      (rr_ptr_q),
        .cap      (cap),
        .win_vec  (win_vec),
        .w0_v     (w0_v),
        .w0_idx   (w0_idx),
        .w1_v     (w1_v),
        .w1_idx   (w1_idx),
        .adv      (adv),
        .next_ptr (next_ptr)
    );

    // Round-robin pointer, advanced only in a slot with winners
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr_q <= '0;
        end else if (slot_strobe && adv) begin
            rr_ptr_q <= next_ptr;
        end
    end

    // Receiver 0 carries the scheduled cell when there is one
    always_comb begin
        if (sched_hit) begin
            rx0_v   = 1'b1;
            rx0_src = sched_src;
            rx1_v   = w0_v;
            rx1_src = w0_idx;
        end else begin
            rx0_v   = w0_v;
            rx0_src = w0_idx;
            rx1_v   = w1_v;
            rx1_src = w1_idx;
        end
    end

endmodule

// File: rtl/spec_out_arb.sv
`timescale 1ns/1ps
module spec_out_arb
    import spec_arb_pkg::*;
#(
    parameter int unsigned N_IN  = 8,
    parameter int unsigned N_OUT = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               slot_strobe,
    input  logic [N_IN-1:0]                    sched_valid,
    input  logic [N_IN*idx_width(N_OUT)-1:0]   sched_dst,
    input  logic [N_IN-1:0]                    spec_valid,
    input  logic [N_IN*idx_width(N_OUT)-1:0]   spec_dst,
    output logic                               result_valid,
    output logic [N_IN-1:0]                    spec_ack,
    output logic [N_OUT-1:0]                   rx0_valid,
    output logic [N_OUT*idx_width(N_IN)-1:0]   rx0_src,
    output logic [N_OUT-1:0]                   rx1_valid,
    output logic [N_OUT*idx_width(N_IN)-1:0]   rx1_src
);

    localparam int unsigned IW = idx_width(N_IN);

    arb_state_t              state_q, state_d;
    logic [N_IN-1:0]         lane_win [N_OUT];
    logic [N_IN-1:0]         ack_c;
    logic [N_OUT-1:0]        rx0_v_c, rx1_v_c;
    logic [N_OUT*IW-1:0]     rx0_s_c, rx1_s_c;

    genvar gj;
    generate
        for (gj = 0; gj < int'(N_OUT); gj++) begin : g_lane
            spec_out_lane #(
                .N_IN  (N_IN),
                .N_OUT (N_OUT),
                .LANE  (gj)
            ) u_lane (
                .clk         (clk),
                .rst_n       (rst_n),
                .slot_strobe (slot_strobe),
                .sched_valid (sched_valid),
                .sched_dst   (sched_dst),
                .spec_valid  (spec_valid),
                .spec_dst    (spec_dst),
                .win_vec     (lane_win[gj]),
                .rx0_v       (rx0_v_c[gj]),
                .rx0_src     (rx0_s_c[gj*IW +: IW]),
                .rx1_v       (rx1_v_c[gj]),
                .rx1_src     (rx1_s_c[gj*IW +: IW])
            );
        end
    endgenerate

    // Each input targets one output, so the per-output wins never overlap
    always_comb begin
        ack_c = '0;
        for (int j = 0; j < int'(N_OUT); j++) begin
            ack_c = ack_c | lane_win[j];
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  state_d = slot_strobe ? ARB_ISSUE : ARB_IDLE;
            ARB_ISSUE: state_d = slot_strobe ? ARB_ISSUE : ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered result fields: loaded on a strobe, cleared otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_ack  <= '0;
            rx0_valid <= '0;
            rx0_src   <= '0;
            rx1_valid <= '0;
            rx1_src   <= '0;
        end else if (slot_strobe) begin
            spec_ack  <= ack_c;
            rx0_valid <= rx0_v_c;
            rx0_src   <= rx0_s_c;
            rx1_valid <= rx1_v_c;
            rx1_src   <= rx1_s_c;
        end else begin
            spec_ack  <= '0;
            rx0_valid <= '0;
            rx0_src   <= '0;
            rx1_valid <= '0;
            rx1_src   <= '0;
        end
    end

    assign result_valid = (state_q == ARB_ISSUE);

endmodule

// File: rtl/spec_out_arb_chk.sv
`timescale 1ns/1ps
module spec_out_arb_chk #(
    parameter int unsigned N_IN  = 8,
    parameter int unsigned N_OUT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_strobe,
    input logic [N_IN-1:0]   sched_valid,
    input logic [N_IN-1:0]   spec_valid,
    input logic              result_valid,
    input logic [N_IN-1:0]   spec_ack,
    input logic [N_OUT-1:0]  rx0_valid,
    input logic [N_OUT-1:0]  rx1_valid
);

    // R1
    strobe_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_strobe |=> result_valid);

    // R1
    no_strobe_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_strobe |=> !result_valid);

    // R1
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> (spec_ack == '0 && rx0_valid == '0 && rx1_valid == '0));

    // R7
    ack_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ((spec_ack & ~$past(spec_valid & ~sched_valid)) == '0));

    // R4
    rx_fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx1_valid & ~rx0_valid) == '0);

    // R3
    receiver_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (($countones(spec_ack) + $countones($past(sched_valid))) ==
                          ($countones(rx0_valid) + $countones(rx1_valid))));

endmodule

bind spec_out_arb spec_out_arb_chk #(
    .N_IN  (N_IN),
    .N_OUT (N_OUT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_strobe  (slot_strobe),
    .sched_valid  (sched_valid),
    .spec_valid   (spec_valid),
    .result_valid (result_valid),
    .spec_ack     (spec_ack),
    .rx0_valid    (rx0_valid),
    .rx1_valid    (rx1_valid)
);

// File: tb/spec_out_arb_bench.sv
`timescale 1ns/1ps
module spec_out_arb_bench;

    localparam int N  = 8;
    localparam int OW = 3;
    localparam int IW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              slot_strobe = 1'b0;
    logic [N-1:0]      sv = '0;
    logic [N-1:0]      pv = '0;
    int                sd [N];
    int                pd [N];
    logic [N*OW-1:0]   sched_dst, spec_dst;
    logic              result_valid;
    logic [N-1:0]      spec_ack, rx0_valid, rx1_valid;
    logic [N*IW-1:0]   rx0_src, rx1_src;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    int           rr [N];
    logic [N-1:0] e_ack, e_r0v, e_r1v;
    int           e_r0s [N];
    int           e_r1s [N];

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            sched_dst[i*OW +: OW] = sd[i][OW-1:0];
            spec_dst[i*OW +: OW]  = pd[i][OW-1:0];
        end
    end

    spec_out_arb #(.N_IN(N), .N_OUT(N)) u_spec_out_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_strobe  (slot_strobe),
        .sched_valid  (sv),
        .sched_dst    (sched_dst),
        .spec_valid   (pv),
        .spec_dst     (spec_dst),
        .result_valid (result_valid),
        .spec_ack     (spec_ack),
        .rx0_valid    (rx0_valid),
        .rx0_src      (rx0_src),
        .rx1_valid    (rx1_valid),
        .rx1_src      (rx1_src)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_req();
        sv = '0;
        pv = '0;
        for (int i = 0; i < N; i++) begin
            sd[i] = 0;
            pd[i] = 0;
        end
    endtask

    // Predicts one slot from the requirements and advances the model pointers
    task automatic model_slot();
        e_ack = '0; e_r0v = '0; e_r1v = '0;
        for (int j = 0; j < N; j++) begin
            bit sh; int ss; int cap; int cnt; int w0; int w1;
            sh = 0; ss = 0; cnt = 0; w0 = 0; w1 = 0;
            e_r0s[j] = 0; e_r1s[j] = 0;
            for (int i = 0; i < N; i++) begin
                if (sv[i] && sd[i] == j) begin sh = 1; ss = i; end
            end
            cap = sh ? 1 : 2;
            for (int k = 0; k < N; k++) begin
                int idx;
                idx = (rr[j] + k) % N;
                if (pv[idx] && !sv[idx] && pd[idx] == j && cnt < cap) begin
                    if (cnt == 0) w0 = idx; else w1 = idx;
                    cnt++;
                    e_ack[idx] = 1'b1;
                end
            end
            if (sh) begin
                e_r0v[j] = 1'b1; e_r0s[j] = ss;
                e_r1v[j] = (cnt > 0); e_r1s[j] = w0;
            end else begin
                e_r0v[j] = (cnt > 0); e_r0s[j] = w0;
                e_r1v[j] = (cnt > 1); e_r1s[j] = w1;
            end
            if (cnt == 1) rr[j] = (w0 + 1) % N;
            if (cnt == 2) rr[j] = (w1 + 1) % N;
        end
    endtask

    task automatic check_result(input string tag);
        chk("R1", {tag, " result_valid"}, int'(result_valid), 1);
        chk("R6", {tag, " spec_ack"}, int'(spec_ack), int'(e_ack));
        chk("R4", {tag, " rx0_valid"}, int'(rx0_valid), int'(e_r0v));
        chk("R3", {tag, " rx1_valid"}, int'(rx1_valid), int'(e_r1v));
        for (int j = 0; j < N; j++) begin
            if (e_r0v[j]) chk("R8", {tag, " rx0_src"}, int'(rx0_src[j*IW +: IW]), e_r0s[j]);
            if (e_r1v[j]) chk("R5", {tag, " rx1_src"}, int'(rx1_src[j*IW +: IW]), e_r1s[j]);
        end
    endtask

    // One slot: requests already placed in sv/pv/sd/pd
    task automatic run_slot(input string tag);
        @(negedge clk);
        slot_strobe = 1'b1;
        model_slot();
        @(negedge clk);
        slot_strobe = 1'b0;
        clear_req();
        check_result(tag);
        @(negedge clk);
        chk("R1", {tag, " result drops"}, int'(result_valid), 0);
        chk("R1", {tag, " ack cleared"}, int'(spec_ack), 0);
    endtask

    task automatic t_reset();
        chk("R1", "reset result_valid", int'(result_valid), 0);
        chk("R1", "reset spec_ack", int'(spec_ack), 0);
        chk("R1", "reset rx valid", int'(rx0_valid | rx1_valid), 0);
    endtask

    task automatic t_single_spec();
        clear_req();
        pv[2] = 1'b1; pd[2] = 5;
        run_slot("R8 single speculation");
    endtask

    task automatic t_pair_free();
        clear_req();
        pv[1] = 1'b1; pd[1] = 0;
        pv[6] = 1'b1; pd[6] = 0;
        run_slot("R4 two winners free output");
    endtask

    task automatic t_rr_rotate();
        for (int s = 0; s < 3; s++) begin
            clear_req();
            pv[0] = 1'b1; pd[0] = 4;
            pv[3] = 1'b1; pd[3] = 4;
            pv[5] = 1'b1; pd[5] = 4;
            pv[7] = 1'b1; pd[7] = 4;
            run_slot("R5 round robin rotation");
        end
    endtask

    task automatic t_sched_share();
        clear_req();
        sv[4] = 1'b1; sd[4] = 2;
        pv[0] = 1'b1; pd[0] = 2;
        pv[1] = 1'b1; pd[1] = 2;
        pv[7] = 1'b1; pd[7] = 2;
        run_slot("R2 R3 scheduled plus speculation");
    endtask

    task automatic t_sched_ignore();
        clear_req();
        sv[3] = 1'b1; sd[3] = 6;
        pv[3] = 1'b1; pd[3] = 1;
        run_slot("R7 granted input speculation");
        chk("R7", "no receiver at speculative target", int'(rx0_valid[1]), 0);
        // Pointer of output 1 must still be at 0: inputs 0 and 3 both ask now
        clear_req();
        pv[3] = 1'b1; pd[3] = 1;
        pv[0] = 1'b1; pd[0] = 1;
        pv[5] = 1'b1; pd[5] = 1;
        run_slot("R7 pointer untouched");
    endtask

    task automatic t_no_strobe();
        clear_req();
        pv[6] = 1'b1; pd[6] = 3;
        pv[2] = 1'b1; pd[2] = 3;
        sv[1] = 1'b1; sd[1] = 3;
        repeat (3) begin
            @(negedge clk);
            chk("R9", "no strobe result_valid", int'(result_valid), 0);
            chk("R9", "no strobe ack", int'(spec_ack), 0);
        end
        clear_req();
        pv[6] = 1'b1; pd[6] = 3;
        pv[2] = 1'b1; pd[2] = 3;
        pv[4] = 1'b1; pd[4] = 3;
        run_slot("R9 pointer held without strobe");
    endtask

    task automatic t_back_to_back();
        clear_req();
        pv[5] = 1'b1; pd[5] = 7;
        sv[0] = 1'b1; sd[0] = 7;
        @(negedge clk);
        slot_strobe = 1'b1;
        model_slot();
        @(negedge clk);
        check_result("R1 back-to-back first");
        clear_req();
        pv[5] = 1'b1; pd[5] = 7;
        pv[6] = 1'b1; pd[6] = 7;
        model_slot();
        @(negedge clk);
        slot_strobe = 1'b0;
        clear_req();
        check_result("R1 back-to-back second");
        @(negedge clk);
        chk("R1", "back-to-back drop", int'(result_valid), 0);
    endtask

    task automatic t_mixed_load();
        clear_req();
        sv[0] = 1'b1; sd[0] = 0;
        sv[1] = 1'b1; sd[1] = 1;
        pv[1] = 1'b1; pd[1] = 0;
        pv[2] = 1'b1; pd[2] = 0;
        pv[3] = 1'b1; pd[3] = 5;
        pv[4] = 1'b1; pd[4] = 5;
        pv[5] = 1'b1; pd[5] = 5;
        pv[6] = 1'b1; pd[6] = 1;
        pv[7] = 1'b1; pd[7] = 6;
        run_slot("R6 mixed load");
    endtask

    initial begin
        for (int j = 0; j < N; j++) rr[j] = 0;
        clear_req();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_spec();
        t_pair_free();
        t_rr_rotate();
        t_sched_share();
        t_sched_ignore();
        t_no_strobe();
        t_back_to_back();
        t_mixed_load();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule